// File: doc/BRIEF.md
# Gated Fractional Count Divider

This block produces the count-enable strobe that advances a PWM slice's counter. It divides a stream of qualifying events by an unsigned fixed-point divisor with an 8-bit whole part and a 4-bit fraction in sixteenths. Over many events, one strobe is issued for every divisor-worth of events.

A 2-bit mode selects what counts as an event. In free mode every enabled clock cycle is an event. In the other modes events come from an external pin. The pin can act as a level gate: each cycle with the pin high is an event. It can also act as an edge source, where each rising or each falling transition is an event. The pin first passes through a two-flop synchronizer.

An enable input stops the divider. While the enable is low, the remainder held by the divider is cleared and no strobe is produced.

Top module: `frac_count_divider`

## Requirements
- R1: After reset, cnt_en is low, and the divider remainder is zero.
- R2: The divisor in sixteenths is div_int*16 + div_frac. A div_int of 0 stands for 256, so the divisor 0.0 yields one strobe per 256 free-mode cycles.
- R3: Each event adds 16 to a remainder. When the sum reaches or exceeds the divisor, a strobe is issued and the divisor is subtracted from the sum. A divisor of 1.0 therefore strobes on every event, and 2.5 strobes twice in every five events.
- R4: mode 0 (free): every clock edge with en high is an event. The strobe is registered on that same edge.
- R5: mode 1 (level gate): an edge is an event when the synchronized pin is high.
- R6: mode 2 (rising): an edge is an event when the synchronized pin has just changed from 0 to 1.
- R7: mode 3 (falling): an edge is an event when the synchronized pin has just changed from 1 to 0.
- R8: A pin value first sampled at clock edge k takes part in the event decision at edge k+2. Any resulting strobe is visible after edge k+2.
- R9: While en is low, no strobe is produced and the remainder is cleared. After re-enabling, division restarts from a zero remainder.
- R10: cnt_en is high for exactly one cycle per event that crosses the divisor; it is never issued on a cycle that is not an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Divider enable; low clears and stops it |
| mode | input | 2 | Event source: 0 free, 1 pin-high gate, 2 rising edge, 3 falling edge |
| div_int | input | 8 | Whole part of the divisor (0 means 256) |
| div_frac | input | 4 | Fractional part of the divisor in sixteenths |
| pin_in | input | 1 | Asynchronous external pin |
| cnt_en | output | 1 | One-cycle count-enable strobe |

## Verification
The hardest state to reach is a non-zero remainder meeting a mode or divisor change. The pin history also straddles the change, so the edge detector's view lags the mode input by two cycles. The stimulus runs random segments, each with a new mode and divisor, and changes them without clearing the remainder. Within a segment it drops the enable at random moments and holds the pin for random lengths of one to four cycles. Directed runs cover the 256-cycle wrap of a zero whole part, a single-cycle pin pulse for latency, and the restart after disable.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    // Event source selection; encoding is part of the block's interface.
    typedef enum logic [1:0] {
        FCD_FREE      = 2'd0,
        FCD_GATE_HIGH = 2'd1,
        FCD_EDGE_RISE = 2'd2,
        FCD_EDGE_FALL = 2'd3
    } fcd_mode_e;

endpackage

// File: rtl/fcd_pin_sync.sv
module fcd_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_st_t;

    sync_st_t st_d, st_q;
    logic [STAGES-1:0] chain_shift;

    generate
        if (STAGES == 1) begin : g_single
            assign chain_shift = pin_i;
        end else begin : g_multi
            assign chain_shift = {st_q.chain[STAGES-2:0], pin_i};
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        st_d.chain = chain_shift;
        st_d.last  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.chain[STAGES-1];
    assign rise_o  = st_q.chain[STAGES-1] & ~st_q.last;
    assign fall_o  = ~st_q.chain[STAGES-1] & st_q.last;

endmodule

// File: rtl/fcd_event_sel.sv
module fcd_event_sel
    import fcd_pkg::*;
(
    input  logic       en,
    input  logic [1:0] mode,
    input  logic       level_i,
    input  logic       rise_i,
    input  logic       fall_i,
    output logic       event_o
);

    always_comb begin
        event_o = 1'b0;
        if (en) begin
            case (fcd_mode_e'(mode))
                FCD_FREE:      event_o = 1'b1;
                FCD_GATE_HIGH: event_o = level_i;
                FCD_EDGE_RISE: event_o = rise_i;
                FCD_EDGE_FALL: event_o = fall_i;
                default:       event_o = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/fcd_accum.sv
module fcd_accum #(
    parameter int unsigned INT_W  = 8,
    parameter int unsigned FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              event_i,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic              pulse_o
);

    // One extra bit so that a zero whole part can stand for 2**INT_W.
    localparam int unsigned ACC_W = INT_W + FRAC_W + 1;
    localparam int unsigned SUM_W = ACC_W + 1;
    localparam int unsigned STEP  = 1 << FRAC_W;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             pulse;
    } acc_st_t;

    acc_st_t          st_d, st_q;
    logic [ACC_W-1:0] divisor;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] wide_div;

    always_comb begin
        if (div_int == '0) begin
            divisor = {1'b1, {INT_W{1'b0}}, div_frac};
        end else begin
            divisor = {1'b0, div_int, div_frac};
        end
        wide_div = {1'b0, divisor};
        sum      = {1'b0, st_q.acc} + SUM_W'(STEP);

        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (!en) begin
            st_d.acc = '0;
        end else if (event_i) begin
            if (sum >= wide_div) begin
                st_d.pulse = 1'b1;
                st_d.acc   = ACC_W'(sum - wide_div);
            end else begin
                st_d.acc   = ACC_W'(sum);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = st_q.pulse;

endmodule

// File: rtl/frac_count_divider.sv
module frac_count_divider #(
    parameter int unsigned INT_W       = 8,
    parameter int unsigned FRAC_W      = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [1:0]        mode,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    input  logic              pin_in,
    output logic              cnt_en
);

    logic pin_level;
    logic pin_rise;
    logic pin_fall;
    logic qual_event;

    fcd_pin_sync #(
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pin_in),
        .level_o (pin_level),
        .rise_o  (pin_rise),
        .fall_o  (pin_fall)
    );

    fcd_event_sel sel_i (
        .en      (en),
        .mode    (mode),
        .level_i (pin_level),
        .rise_i  (pin_rise),
        .fall_i  (pin_fall),
        .event_o (qual_event)
    );

    fcd_accum #(
        .INT_W  (INT_W),
        .FRAC_W (FRAC_W)
    ) accum_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .event_i  (qual_event),
        .div_int  (div_int),
        .div_frac (div_frac),
        .pulse_o  (cnt_en)
    );

endmodule

// File: rtl/frac_count_divider_chk.sv
module frac_count_divider_chk #(
    parameter int unsigned INT_W  = 8,
    parameter int unsigned FRAC_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic [1:0]        mode,
    input logic [INT_W-1:0]  div_int,
    input logic [FRAC_W-1:0] div_frac,
    input logic              pin_in,
    input logic              cnt_en
);

    // Edges since reset, saturating; pin history checks need a full window.
    logic [2:0] since_rst;
    logic       warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 3'd7) begin
            since_rst <= since_rst + 3'd1;
        end
    end

    assign warm = (since_rst >= 3'd6);

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !cnt_en);

    assert_unit_div_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == 2'd0 && div_int == INT_W'(1) && div_frac == '0) |=> cnt_en);

    assert_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && cnt_en && $past(mode) == 2'd1) |-> $past(pin_in, 3));

    assert_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && cnt_en && $past(mode) == 2'd2) |-> ($past(pin_in, 3) && !$past(pin_in, 4)));

    assert_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && cnt_en && $past(mode) == 2'd3) |-> (!$past(pin_in, 3) && $past(pin_in, 4)));

endmodule

bind frac_count_divider frac_count_divider_chk #(
    .INT_W  (INT_W),
    .FRAC_W (FRAC_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .mode     (mode),
    .div_int  (div_int),
    .div_frac (div_frac),
    .pin_in   (pin_in),
    .cnt_en   (cnt_en)
);

// File: tb/frac_count_divider_tb_top.sv
module frac_count_divider_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [7:0] div_int = 8'd1;
    logic [3:0] div_frac = 4'd0;
    logic       pin_in = 1'b0;
    logic       cnt_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference state in the bench
    int    ref_acc = 0;
    bit    exp_q = 1'b0;
    bit    h1 = 1'b0, h2 = 1'b0, h3 = 1'b0;
    string tag_q = "R1";

    always #10 clk = ~clk;

    frac_count_divider dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .mode     (mode),
        .div_int  (div_int),
        .div_frac (div_frac),
        .pin_in   (pin_in),
        .cnt_en   (cnt_en)
    );

    function automatic int divisor16(input logic [7:0] di, input logic [3:0] df);
        return ((di == 8'd0) ? 256 : int'(di)) * 16 + int'(df);
    endfunction

    function automatic string auto_tag(input logic e, input logic [1:0] m);
        if (!e) return "R9";
        case (m)
            2'd0: return "R4";
            2'd1: return "R5";
            2'd2: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Expected result of the coming clock edge, from R2..R9.
    task automatic model_edge();
        bit ev;
        ev = 1'b0;
        if (!en) begin
            ref_acc = 0;
        end else begin
            case (mode)
                2'd0: ev = 1'b1;
                2'd1: ev = h2;
                2'd2: ev = h2 & ~h3;
                default: ev = ~h2 & h3;
            endcase
        end
        exp_q = 1'b0;
        if (ev) begin
            ref_acc = ref_acc + 16;
            if (ref_acc >= divisor16(div_int, div_frac)) begin
                exp_q   = 1'b1;
                ref_acc = ref_acc - divisor16(div_int, div_frac);
            end
        end
        h3 = h2;
        h2 = h1;
        h1 = pin_in;
    endtask

    task automatic check(input string tag, input logic act, input bit exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: cnt_en actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Called just after a falling edge: check, drive, predict, advance.
    task automatic tick(input logic p, input string tag);
        check(tag_q, cnt_en, exp_q);
        pin_in = p;
        model_edge();
        tag_q = (tag == "") ? auto_tag(en, mode) : tag;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state observed before any enable
        tick(1'b0, "R1");
        tick(1'b0, "R1");

        // R3: divisor 1.0 strobes every free cycle (R4 timing)
        en = 1'b1; mode = 2'd0; div_int = 8'd1; div_frac = 4'd0;
        for (int i = 0; i < 12; i++) tick(1'b0, "R3");

        // R3: divisor 2.5 gives two strobes per five cycles
        en = 1'b0; tick(1'b0, "R9");
        en = 1'b1; div_int = 8'd2; div_frac = 4'd8;
        for (int i = 0; i < 40; i++) tick(1'b0, "R3");

        // R2: whole part zero means 256
        en = 1'b0; tick(1'b0, "R9");
        en = 1'b1; div_int = 8'd0; div_frac = 4'd0;
        for (int i = 0; i < 600; i++) tick(1'b0, "R2");

        // R8: single-cycle pin pulse in gate mode, divisor 1.0
        en = 1'b0; tick(1'b0, "R9");
        en = 1'b1; mode = 2'd1; div_int = 8'd1; div_frac = 4'd0;
        for (int i = 0; i < 4; i++) tick(1'b0, "R8");
        tick(1'b1, "R8");
        for (int i = 0; i < 6; i++) tick(1'b0, "R8");

        // R10: rising edges with divisor 1.0, one strobe per edge
        mode = 2'd2;
        for (int i = 0; i < 4; i++) begin
            tick(1'b1, "R10"); tick(1'b1, "R10"); tick(1'b0, "R10"); tick(1'b0, "R10");
        end

        // R9: disable clears remainder, restart from zero with divisor 3.0
        mode = 2'd0; div_int = 8'd2; div_frac = 4'd0;
        tick(1'b0, "R9");
        en = 1'b0;
        for (int i = 0; i < 8; i++) tick(1'b0, "R9");
        en = 1'b1; div_int = 8'd3;
        for (int i = 0; i < 12; i++) tick(1'b0, "R9");

        // Random segments with fresh mode and divisor each time
        for (int seg = 0; seg < 16; seg++) begin
            logic pv;
            int   hold;
            mode     = 2'($urandom_range(0, 3));
            div_int  = 8'($urandom_range(1, 4));
            div_frac = 4'($urandom_range(0, 15));
            pv   = 1'b0;
            hold = 0;
            for (int i = 0; i < 300; i++) begin
                if (hold == 0) begin
                    pv   = ~pv;
                    hold = $urandom_range(1, 4);
                end
                hold--;
                en = ($urandom_range(0, 19) != 0);
                tick(pv, "");
            end
        end
        en = 1'b1;
        tick(1'b0, "");

        done = 1'b1;
        summary();
    end

endmodule